// File: doc/BRIEF.md
# Video Line Clamp Pulse Generator

This block produces one clamp timing pulse per video line for a pedestal clamp. It runs on the pixel-rate sample clock. It takes an asynchronous horizontal sync input and finds its falling edges. From each edge it times a pulse whose delay and length come from an 8-bit control register. The register holds two 3-bit codes. Each code indexes a fixed, non-uniform table of clock counts, so steps between neighbouring codes are not equal.

A 3-bit clamp-mode input selects the source of the clamp output. In one mode the internally timed pulse drives the output. In another mode an external clamp input passes straight through. Any other mode holds the output low. A separate 2-bit monitor-select input can copy the internal pulse to a monitor pin, but only in the internal mode. The top two register bits are slice-level bits. They are only stored and read back.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset `cfg_o` is 8'h1C. A write with `cfg_we_i` high loads `cfg_wdata_i`, and `cfg_o` shows it after that clock edge. Field layout: [7:6] slice level, [5:3] width code, [2:0] start code.
- R2: Take the first rising clock edge that samples `hsync_i` low after it was high as edge 1. In mode 3'b010, `clamp_o` rises after edge S+3. S is 118, 126, 132, 140, 148, 156, 164 or 172 for start codes 0 to 7.
- R3: In mode 3'b010, `clamp_o` stays high for exactly W clocks and falls after edge S+W+3. W is 16, 24, 28, 32, 40, 44, 48 or 52 for width codes 0 to 7.
- R4: With the reset register value, the pulse rises after edge 151 and falls after edge 183.
- R5: A new sync falling edge during an active pulse ends the pulse: `clamp_o` is low after edge 3 of the new line. Timing then restarts from the new edge.
- R6: A register write made mid-line does not change the current line. It takes effect from the next sync falling edge.
- R7: In mode 3'b110, `clamp_o` equals `ext_clamp_i` on every cycle, whatever the register codes and sync edges are.
- R8: In any mode other than 3'b010 and 3'b110, `clamp_o` is low.
- R9: `mon_o` equals the internal pulse only when the mode is 3'b010 and `mon_sel_i` is 2'b01. Otherwise `mon_o` is low.
- R10: The slice-level bits [7:6] are stored and read back on `cfg_o`. They have no effect on pulse timing.
- R11: During and right after reset, `clamp_o` and `mon_o` are low in mode 3'b010 until a sync edge has been timed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Asynchronous horizontal sync, active low |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control register write data |
| clamp_mode_i | input | 3 | Clamp source select: 010 internal, 110 external |
| mon_sel_i | input | 2 | Monitor select: 01 exposes the internal pulse |
| ext_clamp_i | input | 1 | External clamp pulse |
| cfg_o | output | 8 | Current control register value |
| clamp_o | output | 1 | Clamp timing pulse |
| mon_o | output | 1 | Monitor copy of the internal pulse |

## Verification
The bench builds the block with its defaults: a two-stage sync chain and an 8-bit line counter. With these values the longest pulse end, 224 clocks, fits in the counter, and the counter saturates at 255 with room to spare. This lets the bench sweep all eight start codes and all eight width codes, and check each edge at the exact clock. It can also place a second sync edge inside a pulse at a known cycle offset.

// File: rtl/clamp_pulse_pkg.sv
package clamp_pulse_pkg;
  localparam int unsigned CODE_W = 3;
  localparam logic [7:0] CFG_RESET = 8'h1C;
  localparam logic [2:0] MODE_INT = 3'b010;
  localparam logic [2:0] MODE_EXT = 3'b110;
  localparam logic [1:0] MON_INT = 2'b01;

  function automatic logic [7:0] start_clocks(input logic [CODE_W-1:0] code);
    case (code)
      3'd0: start_clocks = 8'd118;
      3'd1: start_clocks = 8'd126;
      3'd2: start_clocks = 8'd132;
      3'd3: start_clocks = 8'd140;
      3'd4: start_clocks = 8'd148;
      3'd5: start_clocks = 8'd156;
      3'd6: start_clocks = 8'd164;
      default: start_clocks = 8'd172;
    endcase
  endfunction

  function automatic logic [7:0] width_clocks(input logic [CODE_W-1:0] code);
    case (code)
      3'd0: width_clocks = 8'd16;
      3'd1: width_clocks = 8'd24;
      3'd2: width_clocks = 8'd28;
      3'd3: width_clocks = 8'd32;
      3'd4: width_clocks = 8'd40;
      3'd5: width_clocks = 8'd44;
      3'd6: width_clocks = 8'd48;
      default: width_clocks = 8'd52;
    endcase
  endfunction
endpackage

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/clamp_cfg_reg.sv
module clamp_cfg_reg
  import clamp_pulse_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   cfg_o <= CFG_RESET;
    else if (we_i) cfg_o <= wdata_i;
endmodule

// File: rtl/clamp_pulse_timer.sv
module clamp_pulse_timer
  import clamp_pulse_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [CODE_W-1:0] start_code_i,
  input  logic [CODE_W-1:0] width_code_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  start_cnt_o,
  output logic [CNT_W-1:0]  width_cnt_o,
  output logic              pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CODE_W-1:0] start_sh_q, width_sh_q;
  logic [CNT_W-1:0]  rise_at, drop_at;

  assign start_cnt_o = CNT_W'(start_clocks(start_sh_q));
  assign width_cnt_o = CNT_W'(width_clocks(width_sh_q));
  assign rise_at     = start_cnt_o - 1'b1;
  assign drop_at     = start_cnt_o + width_cnt_o - 1'b1;

  // codes are latched at each sync edge so mid-line writes wait a line
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      start_sh_q <= CFG_RESET[2:0];
      width_sh_q <= CFG_RESET[5:3];
      cnt_o      <= CNT_MAX;
      pulse_o    <= 1'b0;
    end else if (fall_i) begin
      start_sh_q <= start_code_i;
      width_sh_q <= width_code_i;
      cnt_o      <= '0;
      pulse_o    <= 1'b0;
    end else begin
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (!pulse_o && cnt_o == rise_at)    pulse_o <= 1'b1;
      else if (pulse_o && cnt_o == drop_at) pulse_o <= 1'b0;
    end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pulse_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hsync_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic [2:0] clamp_mode_i,
  input  logic [1:0] mon_sel_i,
  input  logic       ext_clamp_i,
  output logic [7:0] cfg_o,
  output logic       clamp_o,
  output logic       mon_o
);
  logic             fall_w, pulse_w;
  logic [CNT_W-1:0] cnt_w, start_cnt_w, width_cnt_w;

  clamp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(hsync_i), .fall_o(fall_w)
  );

  clamp_cfg_reg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg_o)
  );

  clamp_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall_w),
    .start_code_i(cfg_o[2:0]), .width_code_i(cfg_o[5:3]),
    .cnt_o(cnt_w), .start_cnt_o(start_cnt_w), .width_cnt_o(width_cnt_w),
    .pulse_o(pulse_w)
  );

  always_comb begin
    case (clamp_mode_i)
      MODE_INT: clamp_o = pulse_w;
      MODE_EXT: clamp_o = ext_clamp_i;
      default:  clamp_o = 1'b0;
    endcase
  end

  assign mon_o = pulse_w & (clamp_mode_i == MODE_INT) & (mon_sel_i == MON_INT);
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [7:0]       cfg_wdata_i,
  input logic [7:0]       cfg_o,
  input logic [2:0]       clamp_mode_i,
  input logic             mon_o,
  input logic             fall_w,
  input logic             pulse_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] start_cnt_w,
  input logic [CNT_W-1:0] width_cnt_w
);
  a_r1_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_o == $past(cfg_wdata_i));

  a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_w) |-> cnt_w == start_cnt_w);

  a_r3_width_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_w) && !$past(fall_w)) |-> cnt_w == CNT_W'(start_cnt_w + width_cnt_w));

  a_r5_restart_ends_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_w |=> !pulse_w && cnt_w == '0);

  a_r9_mon_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clamp_mode_i != 3'b010) |-> !mon_o);
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_o(cfg_o), .clamp_mode_i(clamp_mode_i), .mon_o(mon_o), .fall_w(fall_w),
  .pulse_w(pulse_w), .cnt_w(cnt_w), .start_cnt_w(start_cnt_w), .width_cnt_w(width_cnt_w)
);

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b1;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] mode = 3'b010;
  logic [1:0] msel = 2'b01;
  logic       ext = 1'b0;
  logic [7:0] cfg;
  logic       clamp, mon;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clamp_pulse_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .clamp_mode_i(mode), .mon_sel_i(msel), .ext_clamp_i(ext),
    .cfg_o(cfg), .clamp_o(clamp), .mon_o(mon)
  );

  int start_tab[8] = '{118, 126, 132, 140, 148, 156, 164, 172};
  int width_tab[8] = '{16, 24, 28, 32, 40, 44, 48, 52};

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // one line: sync low at a negedge; returns edges after which clamp rose/fell
  task automatic run_line(input bit do_wr, input logic [7:0] wd,
                          output int rise, output int fall, output bit mon_ok);
    rise = 0; fall = 0; mon_ok = 1;
    @(negedge clk); hsync = 1'b0;
    for (int i = 1; i <= 250; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 5) hsync = 1'b1;
      if (do_wr && i == 50) we = 1'b1;
      if (do_wr && i == 50) wdata = wd;
      if (do_wr && i == 51) we = 1'b0;
      if (mon !== clamp) mon_ok = 0;
      if (clamp && rise == 0) rise = i;
      if (!clamp && rise != 0 && fall == 0) fall = i;
    end
  endtask

  task automatic t_reset();
    chk(cfg == 8'h1C, "R1 reset value", cfg, 8'h1C);
    repeat (20) @(negedge clk);
    chk(clamp == 1'b0 && mon == 1'b0, "R11 idle after reset", clamp, 0);
  endtask

  task automatic t_default();
    int r, f; bit m;
    run_line(0, 8'h00, r, f, m);
    chk(r == 151, "R4 default rise", r, 151);
    chk(f == 183, "R4 default fall", f, 183);
    chk(m, "R9 monitor follows pulse", m, 1);
  endtask

  task automatic t_start_sweep();
    int r, f; bit m;
    for (int c = 0; c < 8; c++) begin
      wr(8'(c));
      chk(cfg == 8'(c), "R1 write readback", cfg, c);
      run_line(0, 8'h00, r, f, m);
      chk(r == start_tab[c] + 3, "R2 start code", r, start_tab[c] + 3);
      chk(f - r == 16, "R3 width code 0", f - r, 16);
    end
  endtask

  task automatic t_width_sweep();
    int r, f; bit m;
    for (int c = 0; c < 8; c++) begin
      wr(8'(c << 3) | 8'd2);
      run_line(0, 8'h00, r, f, m);
      chk(r == 135, "R2 start code 2", r, 135);
      chk(f == 135 + width_tab[c], "R3 width code", f, 135 + width_tab[c]);
    end
  endtask

  task automatic t_restart();
    int r2; bit hi2, lo3;
    wr(8'h38);  // width 52, start 118
    @(negedge clk); hsync = 1'b0;
    for (int i = 1; i <= 130; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 5) hsync = 1'b1;
    end
    chk(clamp == 1'b1, "R5 pulse active before restart", clamp, 1);
    hsync = 1'b0;
    r2 = 0; hi2 = 0; lo3 = 0;
    for (int j = 1; j <= 250; j++) begin
      @(posedge clk); @(negedge clk);
      if (j == 5) hsync = 1'b1;
      if (j == 2) hi2 = clamp;
      if (j == 3) lo3 = !clamp;
      if (j > 3 && clamp && r2 == 0) r2 = j;
    end
    chk(hi2, "R5 still high at edge 2", hi2, 1);
    chk(lo3, "R5 low after edge 3", lo3, 1);
    chk(r2 == 121, "R5 retimed rise", r2, 121);
  endtask

  task automatic t_midline();
    int r, f; bit m;
    wr(8'h1C);
    run_line(1, 8'h00, r, f, m);
    chk(r == 151 && f == 183, "R6 current line unchanged", r, 151);
    chk(cfg == 8'h00, "R6 write landed", cfg, 0);
    run_line(0, 8'h00, r, f, m);
    chk(r == 121 && f == 137, "R6 next line uses new codes", r, 121);
  endtask

  task automatic t_slice();
    int r, f; bit m;
    wr(8'hDC);
    chk(cfg == 8'hDC, "R10 slice bits stored", cfg, 8'hDC);
    run_line(0, 8'h00, r, f, m);
    chk(r == 151 && f == 183, "R10 slice bits no effect", r, 151);
  endtask

  task automatic t_ext();
    bit ok = 1, mq = 1;
    mode = 3'b110;
    @(negedge clk); hsync = 1'b0;
    for (int i = 1; i <= 220; i++) begin
      ext = (i % 7) < 3;
      #1;
      if (clamp !== ext) ok = 0;
      if (mon !== 1'b0) mq = 0;
      @(posedge clk); @(negedge clk);
      if (i == 5) hsync = 1'b1;
      if (clamp !== ext) ok = 0;
    end
    ext = 1'b0;
    chk(ok, "R7 external passthrough", ok, 1);
    chk(mq, "R9 monitor off in external mode", mq, 1);
  endtask

  task automatic t_off();
    bit ok = 1;
    mode = 3'b000; ext = 1'b1;
    @(negedge clk); hsync = 1'b0;
    for (int i = 1; i <= 220; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 5) hsync = 1'b1;
      if (clamp !== 1'b0 || mon !== 1'b0) ok = 0;
    end
    ext = 1'b0;
    chk(ok, "R8 other mode holds low", ok, 1);
    mode = 3'b010;
  endtask

  task automatic t_mon_sel();
    int r, f; bit m; bit any = 0;
    msel = 2'b00;
    @(negedge clk); hsync = 1'b0;
    for (int i = 1; i <= 220; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 5) hsync = 1'b1;
      if (mon) any = 1;
      if (i == 160) chk(clamp == 1'b1, "R9 pulse present with monitor off", clamp, 1);
    end
    chk(!any, "R9 monitor select off", any, 0);
    msel = 2'b01;
    run_line(0, 8'h00, r, f, m);
    chk(m && r == 151, "R9 monitor select on", r, 151);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_start_sweep();
    t_width_sweep();
    t_restart();
    t_midline();
    t_slice();
    t_ext();
    t_off();
    t_mon_sel();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule